// File: doc/BRIEF.md
# Host Parallel Mailbox Port

This block lets an external host processor trade single bytes with an on-chip core through a byte-wide asynchronous slave port. The host side has an active-low select, active-low read and write strobes, and one register-select line. The data bus is split into an input vector, an output vector and an output enable, and a pad ring outside the block joins them into a bidirectional bus. The host reads either the data byte or a status byte. It writes bytes into the data register.

The block holds one byte travelling toward the host and one byte travelling toward the core. When the core loads an outgoing byte, the block raises an interrupt to the host, which stays high until the host reads that byte. The core uses this, for example, to announce readiness at boot by loading 0xAC. An incoming byte stays in place until the core takes it. A host write that arrives while that byte is still unclaimed is dropped, and a sticky overflow flag records the loss.

All host strobes are asynchronous to the core clock. They pass through a synchroniser chain, and the block acts on the trailing (rising) edge of the read or write strobe as seen in the core clock domain.

Top module: `hostport_mailbox`

## Requirements
- R1: After synchronous reset the interrupt is low, no incoming byte is flagged, the overflow flag is clear, and a status read returns 0x80.
- R2: A read with the select line at 1 returns the status byte. Bit 7 is 1 when no outgoing byte is pending and 0 when one is pending. Bit 6 is 1 when an incoming byte is held and 0 when the port can accept one. Bits 5 to 0 read as 0.
- R3: A read with the select line at 0 returns the pending outgoing byte.
- R4: A core load pulse makes the interrupt high and clears status bit 7 at the next clock edge. A second load before the host reads replaces the byte.
- R5: A completed host data read (read strobe rising while chip select is low and select is 0) drops the interrupt and sets status bit 7. A status read leaves both unchanged.
- R6: A completed host data write (write strobe rising while chip select is low and select is 0) stores the bus byte, flags it to the core and sets status bit 6.
- R7: A write with the select line at 1 changes nothing.
- R8: A data write while an incoming byte is still held is dropped. The held byte is unchanged, and the overflow flag is set and stays set until reset.
- R9: A core take pulse frees the incoming register. If a take and a host write complete in the same cycle, the write is accepted.
- R10: The output enable is high only while chip select and read are both low. Strobes with chip select high have no effect.
- R11: The result of a host strobe edge or a select change appears at the outputs no later than SYNC_STAGES+1 core clock edges after the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_cs_n | input | 1 | Host chip select, active low |
| hp_rd_n | input | 1 | Host read strobe, active low |
| hp_wr_n | input | 1 | Host write strobe, active low |
| hp_sel | input | 1 | Register select: 0 data, 1 status |
| hp_din | input | DW | Host bus data toward the block |
| hp_dout | output | DW | Byte driven onto the host bus |
| hp_doe | output | 1 | Host bus output enable |
| hp_irq | output | 1 | Interrupt: outgoing byte pending |
| core_tx_load | input | 1 | Core pulse: load outgoing byte |
| core_tx_byte | input | DW | Outgoing byte from the core |
| core_rx_valid | output | 1 | Incoming byte held for the core |
| core_rx_byte | output | DW | Incoming byte from the host |
| core_rx_take | input | 1 | Core pulse: incoming byte consumed |
| rx_overflow | output | 1 | Sticky: a host write was dropped |

## Verification
The bench targets the cases a mailbox most easily gets wrong. A status read must not clear the interrupt; a design that decodes the select line badly would drop the interrupt and lose the outgoing byte. A write into an occupied register must leave the held byte intact and set the sticky flag; a faulty design would overwrite the byte without notice. A take that lands in the same cycle as a host write must keep the new byte; a wrong priority would lose it. The bench also drives strobes with chip select high and writes to the status address, so a design that ignores either qualifier shows a spurious interrupt clear or a phantom incoming byte.

// File: rtl/hpmb_pkg.sv
package hpmb_pkg;
  localparam int HPMB_DW   = 8;
  localparam int HPMB_SYNC = 2;

  typedef enum logic {
    SEL_DATA   = 1'b0,
    SEL_STATUS = 1'b1
  } hpmb_sel_e;
endpackage

// File: rtl/hpmb_sync.sv
module hpmb_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= {W{RST_VAL}};
          else     stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= {W{RST_VAL}};
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hpmb_front.sv
module hpmb_front #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          sel,
  input  logic [DW-1:0] din,
  output logic          rd_evt,
  output logic          wr_evt,
  output logic          ev_sel,
  output logic [DW-1:0] ev_data,
  output logic          sel_now
);
  localparam int AW = DW + 1;

  logic [2:0]    ctl_s, ctl_p;
  logic [AW-1:0] ad_s, ad_p;

  hpmb_sync #(.W(3), .STAGES(STAGES), .RST_VAL(1'b1)) u_ctl_sync (
    .clk(clk), .rst(rst), .d({cs_n, rd_n, wr_n}), .q(ctl_s)
  );

  hpmb_sync #(.W(AW), .STAGES(STAGES), .RST_VAL(1'b0)) u_ad_sync (
    .clk(clk), .rst(rst), .d({sel, din}), .q(ad_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_p <= 3'b111;
      ad_p  <= '0;
    end else begin
      ctl_p <= ctl_s;
      ad_p  <= ad_s;
    end
  end

  // trailing edge of a strobe, qualified by the select seen one cycle earlier
  assign rd_evt  = ctl_s[1] & ~ctl_p[1] & ~ctl_p[2];
  assign wr_evt  = ctl_s[0] & ~ctl_p[0] & ~ctl_p[2];
  assign ev_sel  = ad_p[AW-1];
  assign ev_data = ad_p[DW-1:0];
  assign sel_now = ad_s[AW-1];
endmodule

// File: rtl/hpmb_regs.sv
module hpmb_regs
  import hpmb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_evt,
  input  logic          wr_evt,
  input  logic          ev_sel,
  input  logic [DW-1:0] ev_data,
  input  logic          core_tx_load,
  input  logic [DW-1:0] core_tx_byte,
  input  logic          core_rx_take,
  output logic          tx_full,
  output logic [DW-1:0] tx_byte,
  output logic          rx_full,
  output logic [DW-1:0] rx_byte,
  output logic          ovf
);
  logic host_rd, host_wr, rx_accept, rx_drop;

  assign host_rd   = rd_evt & (hpmb_sel_e'(ev_sel) == SEL_DATA);
  assign host_wr   = wr_evt & (hpmb_sel_e'(ev_sel) == SEL_DATA);
  assign rx_accept = host_wr & (~rx_full | core_rx_take);
  assign rx_drop   = host_wr & rx_full & ~core_rx_take;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_full <= 1'b0;
      tx_byte <= '0;
    end else if (core_tx_load) begin
      tx_full <= 1'b1;
      tx_byte <= core_tx_byte;
    end else if (host_rd) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full <= 1'b0;
      rx_byte <= '0;
    end else if (rx_accept) begin
      rx_full <= 1'b1;
      rx_byte <= ev_data;
    end else if (core_rx_take) begin
      rx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf <= 1'b0;
    else if (rx_drop) ovf <= 1'b1;
  end

  // R4
  irq_rise_from_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_full) |-> $past(core_tx_load));

  // R5
  irq_fall_from_data_read_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_full) |-> $past(rd_evt && !ev_sel));

  // R6
  rx_fill_from_data_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(wr_evt && !ev_sel));

  // R8
  held_byte_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !core_rx_take) |=> $stable(rx_byte));

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
endmodule

// File: rtl/hostport_mailbox.sv
module hostport_mailbox
  import hpmb_pkg::*;
#(
  parameter int DW          = HPMB_DW,
  parameter int SYNC_STAGES = HPMB_SYNC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hp_cs_n,
  input  logic          hp_rd_n,
  input  logic          hp_wr_n,
  input  logic          hp_sel,
  input  logic [DW-1:0] hp_din,
  output logic [DW-1:0] hp_dout,
  output logic          hp_doe,
  output logic          hp_irq,
  input  logic          core_tx_load,
  input  logic [DW-1:0] core_tx_byte,
  output logic          core_rx_valid,
  output logic [DW-1:0] core_rx_byte,
  input  logic          core_rx_take,
  output logic          rx_overflow
);
  localparam int TE_BIT = DW - 1;
  localparam int RF_BIT = DW - 2;

  logic          rd_evt, wr_evt, ev_sel, sel_now;
  logic [DW-1:0] ev_data;
  logic          tx_full, rx_full, ovf;
  logic [DW-1:0] tx_byte, rx_byte, status, dout_q;

  hpmb_front #(.DW(DW), .STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst),
    .cs_n(hp_cs_n), .rd_n(hp_rd_n), .wr_n(hp_wr_n),
    .sel(hp_sel), .din(hp_din),
    .rd_evt(rd_evt), .wr_evt(wr_evt),
    .ev_sel(ev_sel), .ev_data(ev_data), .sel_now(sel_now)
  );

  hpmb_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .rd_evt(rd_evt), .wr_evt(wr_evt),
    .ev_sel(ev_sel), .ev_data(ev_data),
    .core_tx_load(core_tx_load), .core_tx_byte(core_tx_byte),
    .core_rx_take(core_rx_take),
    .tx_full(tx_full), .tx_byte(tx_byte),
    .rx_full(rx_full), .rx_byte(rx_byte), .ovf(ovf)
  );

  always_comb begin
    status         = '0;
    status[TE_BIT] = ~tx_full;
    status[RF_BIT] = rx_full;
  end

  always_ff @(posedge clk) begin
    if (rst) dout_q <= '0;
    else     dout_q <= (hpmb_sel_e'(sel_now) == SEL_STATUS) ? status : tx_byte;
  end

  assign hp_dout       = dout_q;
  assign hp_doe        = ~hp_cs_n & ~hp_rd_n;
  assign hp_irq        = tx_full;
  assign core_rx_valid = rx_full;
  assign core_rx_byte  = rx_byte;
  assign rx_overflow   = ovf;

  // R2
  status_low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sel_now) |-> (hp_dout[RF_BIT-1:0] == '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!hp_irq && !core_rx_valid && !rx_overflow));
endmodule

// File: tb/hostport_mailbox_tb.sv
module hostport_mailbox_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hp_cs_n = 1'b1, hp_rd_n = 1'b1, hp_wr_n = 1'b1, hp_sel = 1'b0;
  logic [7:0] hp_din = '0;
  logic [7:0] hp_dout;
  logic       hp_doe, hp_irq;
  logic       core_tx_load = 1'b0;
  logic [7:0] core_tx_byte = '0;
  logic       core_rx_valid;
  logic [7:0] core_rx_byte;
  logic       core_rx_take = 1'b0;
  logic       rx_overflow;

  int  n_chk = 0, n_fail = 0;
  bit  inflight = 1'b1, done = 1'b0;
  bit  m_tx_full = 0, m_rx_full = 0, m_ovf = 0;
  logic [7:0] m_tx_byte = '0, m_rx_byte = '0;

  always #10 clk = ~clk;

  hostport_mailbox u_dut (
    .clk(clk), .rst(rst),
    .hp_cs_n(hp_cs_n), .hp_rd_n(hp_rd_n), .hp_wr_n(hp_wr_n), .hp_sel(hp_sel),
    .hp_din(hp_din), .hp_dout(hp_dout), .hp_doe(hp_doe), .hp_irq(hp_irq),
    .core_tx_load(core_tx_load), .core_tx_byte(core_tx_byte),
    .core_rx_valid(core_rx_valid), .core_rx_byte(core_rx_byte),
    .core_rx_take(core_rx_take), .rx_overflow(rx_overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // per-cycle comparison against the reference model
  always @(posedge clk) begin
    #1;
    if (!inflight && !done) begin
      chk("R11 cycle irq", hp_irq, m_tx_full);
      chk("R11 cycle rx_valid", core_rx_valid, m_rx_full);
      chk("R11 cycle overflow", rx_overflow, m_ovf);
      if (m_rx_full) chk("R11 cycle rx_byte", core_rx_byte, m_rx_byte);
    end
  end

  task automatic core_load(input logic [7:0] b);
    @(negedge clk);
    core_tx_load = 1'b1; core_tx_byte = b;
    m_tx_full = 1; m_tx_byte = b;
    @(negedge clk);
    core_tx_load = 1'b0;
    chk("R4 irq after load", hp_irq, 1);
  endtask

  task automatic core_take();
    @(negedge clk);
    core_rx_take = 1'b1;
    m_rx_full = 0;
    @(negedge clk);
    core_rx_take = 1'b0;
  endtask

  task automatic hread(input logic sel, input logic cs_on, output logic [7:0] val,
                       output logic oe);
    @(negedge clk);
    inflight = 1; hp_sel = sel; hp_cs_n = ~cs_on;
    wait_neg(4);
    hp_rd_n = 1'b0;
    wait_neg(2);
    val = hp_dout; oe = hp_doe;
    hp_rd_n = 1'b1;
    wait_neg(3);
    hp_cs_n = 1'b1;
    wait_neg(3);
    if (cs_on && !sel) m_tx_full = 0;
    inflight = 0;
  endtask

  task automatic hwrite(input logic sel, input logic cs_on, input logic [7:0] b,
                        input bit take_mid);
    @(negedge clk);
    inflight = 1; hp_sel = sel; hp_cs_n = ~cs_on; hp_din = b;
    wait_neg(3);
    hp_wr_n = 1'b0;
    wait_neg(3);
    hp_wr_n = 1'b1;
    if (take_mid) begin
      wait_neg(2);
      core_rx_take = 1'b1;
      wait_neg(1);
      core_rx_take = 1'b0;
    end else begin
      wait_neg(3);
    end
    if (cs_on && !sel) begin
      if (!m_rx_full || take_mid) begin m_rx_full = 1; m_rx_byte = b; end
      else m_ovf = 1;
    end else if (take_mid) begin
      m_rx_full = 0;
    end
    chk("R11 rx_valid settled", core_rx_valid, m_rx_full);
    hp_cs_n = 1'b1;
    wait_neg(3);
    inflight = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic       oe;
    wait_neg(4);
    rst = 1'b0;
    @(negedge clk);
    inflight = 0;

    // R1 reset state
    chk("R1 irq", hp_irq, 0);
    chk("R1 rx_valid", core_rx_valid, 0);
    chk("R1 overflow", rx_overflow, 0);
    hread(1'b1, 1'b1, v, oe);
    chk("R1 status", v, 8'h80);
    chk("R10 oe during read", oe, 1);

    // R4 boot readiness byte, R2 status with pending byte, R3 data read
    core_load(8'hAC);
    hread(1'b1, 1'b1, v, oe);
    chk("R2 status tx pending", v, 8'h00);
    chk("R5 status read keeps irq", hp_irq, 1);
    hread(1'b0, 1'b1, v, oe);
    chk("R3 data read", v, 8'hAC);
    chk("R5 irq cleared", hp_irq, 0);
    hread(1'b1, 1'b1, v, oe);
    chk("R5 status after read", v, 8'h80);

    // R4 overwrite before the host reads
    core_load(8'h11);
    core_load(8'h22);
    // R10 read with chip select high: bus not driven, irq kept
    hread(1'b0, 1'b0, v, oe);
    chk("R10 oe with cs high", oe, 0);
    chk("R10 irq with cs high", hp_irq, 1);
    hread(1'b0, 1'b1, v, oe);
    chk("R4 overwritten byte", v, 8'h22);

    // R6 host write
    hwrite(1'b0, 1'b1, 8'h5A, 1'b0);
    chk("R6 rx_valid", core_rx_valid, 1);
    chk("R6 rx_byte", core_rx_byte, 8'h5A);
    hread(1'b1, 1'b1, v, oe);
    chk("R6 status rx full", v, 8'hC0);

    // R8 write while full
    hwrite(1'b0, 1'b1, 8'h77, 1'b0);
    chk("R8 byte kept", core_rx_byte, 8'h5A);
    chk("R8 overflow set", rx_overflow, 1);

    // R9 take frees; overflow stays
    core_take();
    chk("R9 rx freed", core_rx_valid, 0);
    chk("R8 overflow sticky", rx_overflow, 1);

    // R7 write to status address
    hwrite(1'b1, 1'b1, 8'h33, 1'b0);
    chk("R7 status write ignored", core_rx_valid, 0);
    // R10 write with chip select high
    hwrite(1'b0, 1'b0, 8'h44, 1'b0);
    chk("R10 cs high write ignored", core_rx_valid, 0);

    // R9 take in the same cycle as a host write
    hwrite(1'b0, 1'b1, 8'h10, 1'b0);
    hwrite(1'b0, 1'b1, 8'h20, 1'b1);
    chk("R9 concurrent take keeps new", core_rx_valid, 1);
    chk("R9 concurrent byte", core_rx_byte, 8'h20);
    hread(1'b1, 1'b1, v, oe);
    chk("R2 status idle tx rx full", v, 8'hC0);

    wait_neg(4);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule